// File: doc/BRIEF.md
# Cross-Parity Page ECC Syndrome Decoder

The decoder watches one codeword at a time as it streams out of a page-organised memory, one byte per accepted beat. The first `NUM_BYTES` beats carry data, the next beat carries the stored column parity byte, and the remaining beats carry the stored row-parity pairs. While the bytes pass, the block recomputes the parity of every bit column and a set of complementary row-parity pairs, one pair per address bit. It folds the stored parity into these to form syndromes.

One cycle after the last beat it classifies the codeword. For an odd-count bit failure confined to one data byte it latches that byte's address and the failing bit mask. A combinational correction port then repairs any later read of that address. Program code fetched from the page can therefore run at once, without a second pass over the data.

Top module: `xpc_decoder`

## Requirements
- R1: After reset, `status` is 00, `done` is low, and `fix_out` equals `fix_in` for every address.
- R2: Beat j of a codeword (counting accepted beats only) carries data byte j for j < NUM_BYTES. Beat NUM_BYTES carries the XOR of all data bytes. Row-parity vector bit 2x is the XOR of the parities of data bytes whose address bit x is 1, and bit 2x+1 is the same over bytes whose address bit x is 0. This vector is packed LSB first into the beats that follow.
- R3: `done` pulses high for exactly one cycle, in the cycle after the last beat is accepted, and `status`, `err_addr` and `err_mask` take their new values in that same cycle.
- R4: A codeword that matches its parity reports status 00.
- R5: If exactly one syndrome bit is set, the fault lies in the parity area and status is 00.
- R6: An odd number of flipped bits within one data byte gives status 01, with `err_addr` equal to that byte's index and `err_mask` equal to the flipped bits.
- R7: A nonzero even number of flipped bits within one data byte, with all row syndromes zero, gives status 10.
- R8: Any other nonzero syndrome combination gives status 11, for example faults in two different bytes, or two faulty bits in the row-parity beat. `err_mask` is zero whenever status is not 01.
- R9: `fix_out` is `fix_in ^ err_mask` when status is 01 and `fix_addr` equals `err_addr`, and `fix_in` otherwise.
- R10: Cycles with `in_valid` low do not advance the beat count, and status holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A codeword beat is present on `in_data` |
| in_data | input | DATA_W | Codeword beat |
| fix_addr | input | ADDR_W | Byte address of a later read to repair |
| fix_in | input | DATA_W | Data of that read |
| fix_out | output | DATA_W | Repaired data |
| done | output | 1 | One-cycle pulse: a new result is available |
| status | output | 2 | 00 none, 01 corrected, 10 byte error, 11 multi-bit error |
| err_addr | output | ADDR_W | Address of the correctable byte |
| err_mask | output | DATA_W | Bit mask to invert in that byte |

## Verification
Two functions can fall in the same cycle. A correction read of the flagged address can be made while the next codeword is still streaming in, and the result of that next codeword can land in the very cycle a correction read is presented. The bench provokes both by loading a correctable codeword, then streaming a clean one while holding the correction port on the flagged address. It expects repaired data on every beat up to the final one. In the `done` cycle it expects the data to pass through unchanged, because the new clean status has replaced the old one.

// File: rtl/xpc_pkg.sv
package xpc_pkg;
    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_BYTE  = 2'b10,
        ST_MULTI = 2'b11
    } xpc_status_e;
endpackage

// File: rtl/xpc_syndrome_accum.sv
module xpc_syndrome_accum #(
    parameter int DATA_W    = 8,
    parameter int NUM_BYTES = 16,
    parameter int ADDR_W    = 4,
    parameter int ROW_BITS  = 8,
    parameter int POS_W     = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [POS_W-1:0]    pos,
    input  logic                last,
    output logic [DATA_W-1:0]   col_syn,
    output logic [ROW_BITS-1:0] row_syn
);
    typedef struct packed {
        logic [DATA_W-1:0]   col;
        logic [ROW_BITS-1:0] row;
    } acc_t;

    acc_t acc_q, acc_d, acc_upd;
    logic byte_par;

    always_comb begin
        acc_upd  = acc_q;
        byte_par = ^in_data;
        if (in_valid) begin
            if (pos < POS_W'(NUM_BYTES)) begin
                acc_upd.col = acc_q.col ^ in_data;
                for (int x = 0; x < ADDR_W; x++) begin
                    if (pos[x]) acc_upd.row[2*x]   = acc_q.row[2*x]   ^ byte_par;
                    else        acc_upd.row[2*x+1] = acc_q.row[2*x+1] ^ byte_par;
                end
            end else if (pos == POS_W'(NUM_BYTES)) begin
                acc_upd.col = acc_q.col ^ in_data;
            end else begin
                for (int b = 0; b < ROW_BITS; b++) begin
                    if (pos == POS_W'(NUM_BYTES + 1 + b / DATA_W))
                        acc_upd.row[b] = acc_q.row[b] ^ in_data[b % DATA_W];
                end
            end
        end
        acc_d = last ? '0 : acc_upd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign col_syn = acc_upd.col;
    assign row_syn = acc_upd.row;
endmodule

// File: rtl/xpc_classify.sv
module xpc_classify
    import xpc_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int ROW_BITS = 8
) (
    input  logic [DATA_W-1:0]   col_syn,
    input  logic [ROW_BITS-1:0] row_syn,
    output xpc_status_e         kind,
    output logic [ADDR_W-1:0]   loc
);
    localparam int SYN_W = DATA_W + ROW_BITS;

    logic [SYN_W-1:0] syn;
    logic             at_most_one;
    logic             pairs_split;

    always_comb begin
        syn         = {col_syn, row_syn};
        at_most_one = ((syn & (syn - SYN_W'(1))) == '0);
        pairs_split = 1'b1;
        for (int x = 0; x < ADDR_W; x++) begin
            pairs_split = pairs_split & (row_syn[2*x] ^ row_syn[2*x+1]);
            loc[x]      = row_syn[2*x];
        end
        if (at_most_one)                           kind = ST_CLEAN;
        else if (col_syn != '0 && pairs_split)     kind = ST_FIXED;
        else if (col_syn != '0 && row_syn == '0)   kind = ST_BYTE;
        else                                       kind = ST_MULTI;
    end
endmodule

// File: rtl/xpc_fix_port.sv
module xpc_fix_port
    import xpc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  xpc_status_e       kind,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [DATA_W-1:0] err_mask,
    input  logic [ADDR_W-1:0] fix_addr,
    input  logic [DATA_W-1:0] fix_in,
    output logic [DATA_W-1:0] fix_out
);
    always_comb begin
        if (kind == ST_FIXED && fix_addr == err_addr) fix_out = fix_in ^ err_mask;
        else                                          fix_out = fix_in;
    end
endmodule

// File: rtl/xpc_decoder.sv
module xpc_decoder
    import xpc_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_BYTES = 16,
    localparam int ADDR_W    = $clog2(NUM_BYTES),
    localparam int ROW_BITS  = 2 * ADDR_W,
    localparam int ROW_BYTES = (ROW_BITS + DATA_W - 1) / DATA_W,
    localparam int CW_LEN    = NUM_BYTES + 1 + ROW_BYTES,
    localparam int POS_W     = $clog2(CW_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [ADDR_W-1:0] fix_addr,
    input  logic [DATA_W-1:0] fix_in,
    output logic [DATA_W-1:0] fix_out,
    output logic              done,
    output logic [1:0]        status,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_mask
);
    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic              done;
        xpc_status_e       kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] mask;
    } ctl_t;

    ctl_t              ctl_q, ctl_d;
    logic              last;
    logic [DATA_W-1:0] col_syn;
    logic [ROW_BITS-1:0] row_syn;
    xpc_status_e       cls_kind;
    logic [ADDR_W-1:0] cls_loc;

    assign last = in_valid && (ctl_q.pos == POS_W'(CW_LEN - 1));

    xpc_syndrome_accum #(
        .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W),
        .ROW_BITS(ROW_BITS), .POS_W(POS_W)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .pos(ctl_q.pos), .last(last), .col_syn(col_syn), .row_syn(row_syn)
    );

    xpc_classify #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS)
    ) u_classify (
        .col_syn(col_syn), .row_syn(row_syn), .kind(cls_kind), .loc(cls_loc)
    );

    xpc_fix_port #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_fix (
        .kind(ctl_q.kind), .err_addr(ctl_q.addr), .err_mask(ctl_q.mask),
        .fix_addr(fix_addr), .fix_in(fix_in), .fix_out(fix_out)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = last;
        if (in_valid) ctl_d.pos = last ? '0 : ctl_q.pos + POS_W'(1);
        if (last) begin
            ctl_d.kind = cls_kind;
            ctl_d.addr = (cls_kind == ST_FIXED) ? cls_loc : '0;
            ctl_d.mask = (cls_kind == ST_FIXED) ? col_syn : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{pos: '0, done: 1'b0, kind: ST_CLEAN, addr: '0, mask: '0};
        else        ctl_q <= ctl_d;
    end

    assign done     = ctl_q.done;
    assign status   = ctl_q.kind;
    assign err_addr = ctl_q.addr;
    assign err_mask = ctl_q.mask;

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |=> !ctl_q.done);
    // R3
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |-> $past(in_valid));
    // R10
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.done |-> ($stable(ctl_q.kind) && $stable(ctl_q.mask)));
    // R10
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.pos <= POS_W'(CW_LEN - 1));
    // R6
    odd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.kind == ST_FIXED) |-> (^ctl_q.mask));
    // R8
    idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.kind != ST_FIXED) |-> (ctl_q.mask == '0));
endmodule

// File: tb/xpc_decoder_test.sv
module xpc_decoder_test;
    localparam int M  = 8;
    localparam int K  = 16;
    localparam int A  = 4;
    localparam int RB = 2 * A;
    localparam int N  = K + 1 + (RB + M - 1) / M;

    typedef struct packed {
        logic [7:0] seed;
        logic [7:0] e1_idx;
        logic [7:0] e1_mask;
        logic [7:0] e2_idx;
        logic [7:0] e2_mask;
        logic [1:0] exp_st;
        logic [7:0] exp_addr;
        logic [7:0] exp_mask;
        logic       gap;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{8'd1,  8'd0,  8'h00, 8'd0,  8'h00, 2'b00, 8'd0,  8'h00, 1'b0}, // R4
        '{8'd2,  8'd5,  8'h01, 8'd0,  8'h00, 2'b01, 8'd5,  8'h01, 1'b1}, // R6
        '{8'd3,  8'd16, 8'h04, 8'd0,  8'h00, 2'b00, 8'd0,  8'h00, 1'b0}, // R5
        '{8'd4,  8'd17, 8'h10, 8'd0,  8'h00, 2'b00, 8'd0,  8'h00, 1'b1}, // R5
        '{8'd5,  8'd0,  8'h07, 8'd0,  8'h00, 2'b01, 8'd0,  8'h07, 1'b0}, // R6
        '{8'd6,  8'd15, 8'hFE, 8'd0,  8'h00, 2'b01, 8'd15, 8'hFE, 1'b1}, // R6
        '{8'd7,  8'd9,  8'h03, 8'd0,  8'h00, 2'b10, 8'd0,  8'h00, 1'b0}, // R7
        '{8'd8,  8'd3,  8'h01, 8'd12, 8'h01, 2'b11, 8'd0,  8'h00, 1'b0}, // R8
        '{8'd9,  8'd2,  8'h01, 8'd7,  8'h02, 2'b11, 8'd0,  8'h00, 1'b1}, // R8
        '{8'd10, 8'd4,  8'h01, 8'd16, 8'h01, 2'b11, 8'd0,  8'h00, 1'b0}, // R8
        '{8'd11, 8'd10, 8'h0F, 8'd0,  8'h00, 2'b10, 8'd0,  8'h00, 1'b0}, // R7
        '{8'd12, 8'd17, 8'h03, 8'd0,  8'h00, 2'b11, 8'd0,  8'h00, 1'b1}  // R8
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [M-1:0] in_data = '0;
    logic [A-1:0] fix_addr = '0;
    logic [M-1:0] fix_in = '0;
    logic [M-1:0] fix_out;
    logic         done;
    logic [1:0]   status;
    logic [A-1:0] err_addr;
    logic [M-1:0] err_mask;

    logic [M-1:0] cw [N];
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    xpc_decoder #(.DATA_W(M), .NUM_BYTES(K)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .fix_addr(fix_addr), .fix_in(fix_in), .fix_out(fix_out),
        .done(done), .status(status), .err_addr(err_addr), .err_mask(err_mask)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R2: encoder written from the requirement
    task automatic build(input logic [7:0] seed, input int i1, input logic [7:0] m1,
                         input int i2, input logic [7:0] m2);
        logic [M-1:0]  col = '0;
        logic [RB-1:0] row = '0;
        for (int j = 0; j < K; j++) begin
            logic p;
            cw[j] = M'((int'(seed) * 37 + j * 29 + 11) & 8'hFF);
            col ^= cw[j];
            p = ^cw[j];
            for (int x = 0; x < A; x++) begin
                if (j[x]) row[2*x] ^= p;
                else      row[2*x+1] ^= p;
            end
        end
        cw[K] = col;
        for (int t = K + 1; t < N; t++) cw[t] = '0;
        for (int b = 0; b < RB; b++) cw[K + 1 + b / M][b % M] = row[b];
        cw[i1] ^= m1;
        cw[i2] ^= m2;
    endtask

    // Streams cw; returns at the negedge where done is expected high.
    task automatic stream(input logic gap);
        for (int j = 0; j < N; j++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = cw[j];
            if (gap && j != N - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data  = 8'hA5;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
    endtask

    initial begin
        #(4 * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 status", 32'(status), 0);
        chk("R1 done", 32'(done), 0);
        fix_addr = 4'd5; fix_in = 8'h3C; #1;
        chk("R1 fix passthrough", 32'(fix_out), 32'h3C);
        @(negedge clk); rst_n = 1'b1;

        foreach (VECS[v]) begin
            vec_t e = VECS[v];
            build(e.seed, int'(e.e1_idx), e.e1_mask, int'(e.e2_idx), e.e2_mask);
            stream(e.gap);
            chk($sformatf("R3 done v%0d", v), 32'(done), 1);
            chk($sformatf("R4-class status v%0d", v), 32'(status), 32'(e.exp_st));
            chk($sformatf("R6 addr v%0d", v), 32'(err_addr), 32'(e.exp_addr));
            chk($sformatf("R8 mask v%0d", v), 32'(err_mask), 32'(e.exp_mask));
            fix_addr = e.exp_addr[A-1:0]; fix_in = 8'h5A; #1;
            chk($sformatf("R9 fix hit v%0d", v), 32'(fix_out), 32'(8'h5A ^ e.exp_mask));
            fix_addr = e.exp_addr[A-1:0] + 4'd1; #1;
            chk($sformatf("R9 fix miss v%0d", v), 32'(fix_out), 32'h5A);
            @(negedge clk); #1;
            chk($sformatf("R3 done drop v%0d", v), 32'(done), 0);
        end

        // R10 / R9: correction during next codeword, and in the done cycle
        build(8'd40, 6, 8'h08, 0, 8'h00);
        stream(1'b0);
        chk("R6 setup status", 32'(status), 1);
        build(8'd41, 0, 8'h00, 0, 8'h00);
        fix_addr = 4'd6; fix_in = 8'hF0;
        for (int j = 0; j < N; j++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = cw[j];
            #1;
            chk($sformatf("R10 fix during stream beat%0d", j), 32'(fix_out), 32'hF8);
        end
        @(negedge clk); in_valid = 1'b0; #1;
        chk("R10 status replaced", 32'(status), 0);
        chk("R9 passthrough in done cycle", 32'(fix_out), 32'hF0);

        // R1: reset in mid-codeword restarts the beat count
        build(8'd50, 3, 8'h01, 0, 8'h00);
        for (int j = 0; j < 7; j++) begin
            @(negedge clk); in_valid = 1'b1; in_data = cw[j];
        end
        @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        stream(1'b0);
        chk("R1 restart status", 32'(status), 1);
        chk("R1 restart addr", 32'(err_addr), 3);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule